// File: doc/BRIEF.md
# Multiplexed 16-bit Host Port Slave

This block lets an external host reach a 32-bit internal word space over a narrow shared bus that carries only 16 data bits. On each bus cycle the host picks a target with two select lines and a direction with a read/write line. The targets are a small control register, an address register and a data register. Each 32-bit word, whether an address or a data value, moves as two halfword cycles. A programmable ordering bit decides whether the upper or the lower half travels first.

On the internal side the block drives a word-wide request/acknowledge port with separate write-data and read-data buses. Data writes are posted as one word once both halves have arrived. Data reads fetch the whole word on the first halfword and return the second half from a local copy. A ready output holds the host off while an internal transfer is pending, and also while the local side keeps the port in its hold-off state. The address can be one shared register, or a pair of independent read and write pointers. Either way the address can step forward by one word after each completed data word.

Top module: `hostport16_slave`

## Requirements
- R1: While `hold` is high, `h_rdy` is low from the next clock on. Any host strobe seen during hold changes no register and starts no internal request, and the halfword position flag returns to the first halfword.
- R2: `h_sel` picks the target: 2'b00 control, 2'b01 data with address post-increment, 2'b10 address, 2'b11 data without increment. `h_rnw` high means the host reads and low means the host writes.
- R3: The control register holds three bits: bit 0 is the ordering bit, bit 1 enables dual address registers and bit 2 picks the write address register (1) or the read address register (0) for address accesses in dual mode. A control read returns these bits in `h_dout[2:0]` with zeros above. A control write resets the halfword flag to the first halfword.
- R4: With the ordering bit at 0, the first halfword of every address or data word is bits 31:16. With the bit at 1, the first halfword is bits 15:0. The second halfword is the other half.
- R5: A host access begins when the qualified strobe turns active. The strobe is active when `h_cs_n` is low and `h_ds1_n` differs from `h_ds2_n`. Select, direction and write data are taken from the bus at that point. Both data strobes at the same level, or chip select high, start nothing.
- R6: A data write posts one internal request with `m_we`=1 only after the second halfword. It carries the assembled word at the current write address.
- R7: A data read issues an internal read at the current read address on the first halfword and returns that halfword once `m_ack` arrives. The second halfword comes from the same word without a new request.
- R8: In shared mode (bit 1 = 0) an address write loads both pointers, and address reads return that value. In dual mode, writes use the write pointer and reads use the read pointer, and address accesses reach only the pointer chosen by bit 2.
- R9: With select 2'b01, the pointer used for the access advances by one word after the word completes (in shared mode both advance). With select 2'b11, no pointer changes.
- R10: `m_req` stays high with `m_we`, `m_addr` and `m_wdata` stable until `m_ack`. It drops on the clock after `m_ack`. `h_rdy` is low while `m_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hold | input | 1 | Local hold-off bit; host accesses are refused while high |
| h_cs_n | input | 1 | Host chip select, active low |
| h_ds1_n | input | 1 | Host data strobe one |
| h_ds2_n | input | 1 | Host data strobe two |
| h_sel | input | 2 | Target register select |
| h_rnw | input | 1 | Direction, 1 = host read |
| h_din | input | HW | Halfword from host |
| h_dout | output | HW | Halfword to host |
| h_rdy | output | 1 | Ready to host, low stalls the access |
| m_req | output | 1 | Internal word request |
| m_we | output | 1 | Internal request is a write |
| m_addr | output | AW | Internal word address |
| m_wdata | output | 2*HW | Internal write word |
| m_rdata | input | 2*HW | Internal read word |
| m_ack | input | 1 | Internal request completed |

## Verification
The bound checker watches the internal handshake on every cycle. It checks that a pending request keeps its command stable until acknowledged and then drops, that ready stays low while a request is outstanding or hold is set, and that hold never lets a new request start. Halfword ordering, assembly of words in both orders, the choice between shared and dual pointers, post-increment against no increment, and the rejection of badly qualified strobes depend on sequences of host cycles. Only the bench's scenarios show these, by comparing returned halfwords and internal requests against its reference model.

// File: rtl/hp16_pkg.sv
package hp16_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL     = 2'b00,
    SEL_DATA_INC = 2'b01,
    SEL_ADDR     = 2'b10,
    SEL_DATA     = 2'b11
  } sel_e;

  typedef struct packed {
    logic asel;  // dual mode: 1 = address accesses reach write pointer
    logic dual;  // independent read and write pointers
    logic hwob;  // 1 = low half travels first
  } ctrl_t;

  localparam int CTRL_W = 3;
endpackage

// File: rtl/hp16_strobe.sv
// Synchronises the host bus and reports the cycle the qualified strobe turns active.
module hp16_strobe #(
  parameter int HW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          ds1_n,
  input  logic          ds2_n,
  input  logic [1:0]    sel,
  input  logic          rnw,
  input  logic [HW-1:0] din,
  output logic          start,
  output logic [1:0]    sel_q,
  output logic          rnw_q,
  output logic [HW-1:0] din_q
);
  logic cs_q, ds1_q, ds2_q, act, act_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q  <= 1'b1;
      ds1_q <= 1'b1;
      ds2_q <= 1'b1;
      sel_q <= '0;
      rnw_q <= 1'b0;
      din_q <= '0;
      act_d <= 1'b0;
    end else begin
      cs_q  <= cs_n;
      ds1_q <= ds1_n;
      ds2_q <= ds2_n;
      sel_q <= sel;
      rnw_q <= rnw;
      din_q <= din;
      act_d <= act;
    end
  end

  assign act   = ~cs_q & (ds1_q ^ ds2_q);
  assign start = act & ~act_d;
endmodule

// File: rtl/hp16_addr.sv
// One word pointer, loadable a halfword at a time, with post-increment.
module hp16_addr #(
  parameter int HW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic            wr_hi,
  input  logic [HW-1:0]   wr_val,
  input  logic            inc,
  output logic [2*HW-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)
      q <= '0;
    else if (wr_en && wr_hi)
      q <= {wr_val, q[HW-1:0]};
    else if (wr_en)
      q <= {q[2*HW-1:HW], wr_val};
    else if (inc)
      q <= q + 1'b1;
  end
endmodule

// File: rtl/hostport16_slave.sv
module hostport16_slave
  import hp16_pkg::*;
#(
  parameter int HW = 16,
  parameter int AW = 20
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            hold,
  input  logic            h_cs_n,
  input  logic            h_ds1_n,
  input  logic            h_ds2_n,
  input  logic [1:0]      h_sel,
  input  logic            h_rnw,
  input  logic [HW-1:0]   h_din,
  output logic [HW-1:0]   h_dout,
  output logic            h_rdy,
  output logic            m_req,
  output logic            m_we,
  output logic [AW-1:0]   m_addr,
  output logic [2*HW-1:0] m_wdata,
  input  logic [2*HW-1:0] m_rdata,
  input  logic            m_ack
);
  localparam int WW = 2 * HW;
  localparam int NPTR = 2;  // index 0 = read pointer, 1 = write pointer

  logic          start, rnw_q;
  logic [1:0]    sel_q;
  logic [HW-1:0] din_q;

  hp16_strobe #(.HW(HW)) u_strobe (
    .clk(clk), .rst(rst), .cs_n(h_cs_n), .ds1_n(h_ds1_n), .ds2_n(h_ds2_n),
    .sel(h_sel), .rnw(h_rnw), .din(h_din),
    .start(start), .sel_q(sel_q), .rnw_q(rnw_q), .din_q(din_q)
  );

  ctrl_t         ctrl_q;
  logic          flag_q;      // 0 = next halfword is the first of its word
  logic          busy_q, busy_nxt;
  logic          rd_pend_q, inc_pend_q;
  logic [WW-1:0] wbuf_q, rbuf_q;
  logic          go, hi, is_data, rd_inc, wr_inc;
  sel_e          s;
  logic [NPTR-1:0] p_wr, p_inc;
  logic [WW-1:0]   p_q [NPTR];
  logic [WW-1:0]   sel_ptr;

  assign s       = sel_e'(sel_q);
  assign go      = start & ~hold & ~busy_q;
  assign hi      = ~(flag_q ^ ctrl_q.hwob);
  assign is_data = (s == SEL_DATA_INC) || (s == SEL_DATA);
  assign sel_ptr = (ctrl_q.dual && ctrl_q.asel) ? p_q[1] : p_q[0];

  // Read pointer steps after the second halfword of an incrementing read,
  // write pointer after the acknowledge of an incrementing write.
  assign rd_inc = go & is_data & rnw_q & flag_q & (s == SEL_DATA_INC);
  assign wr_inc = busy_q & m_ack & ~rd_pend_q & inc_pend_q;

  generate
    for (genvar g = 0; g < NPTR; g++) begin : g_ptr
      logic own_inc, other_inc, chosen;
      assign own_inc   = (g == 0) ? rd_inc : wr_inc;
      assign other_inc = (g == 0) ? wr_inc : rd_inc;
      assign chosen    = ~ctrl_q.dual | (ctrl_q.asel == (g == 1));
      assign p_wr[g]   = go & (s == SEL_ADDR) & ~rnw_q & chosen;
      assign p_inc[g]  = own_inc | (other_inc & ~ctrl_q.dual);

      hp16_addr #(.HW(HW)) u_ptr (
        .clk(clk), .rst(rst), .wr_en(p_wr[g]), .wr_hi(hi),
        .wr_val(din_q), .inc(p_inc[g]), .q(p_q[g])
      );
    end
  endgenerate

  always_comb begin
    if (busy_q)
      busy_nxt = ~m_ack;
    else
      busy_nxt = go & is_data & (rnw_q ? ~flag_q : flag_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q     <= '0;
      flag_q     <= 1'b0;
      busy_q     <= 1'b0;
      rd_pend_q  <= 1'b0;
      inc_pend_q <= 1'b0;
      wbuf_q     <= '0;
      rbuf_q     <= '0;
      h_dout     <= '0;
      h_rdy      <= 1'b0;
      m_req      <= 1'b0;
      m_we       <= 1'b0;
      m_addr     <= '0;
      m_wdata    <= '0;
    end else begin
      h_rdy  <= ~hold & ~busy_nxt;
      busy_q <= busy_nxt;

      if (hold && !busy_q)
        flag_q <= 1'b0;

      if (busy_q && m_ack) begin
        m_req <= 1'b0;
        if (rd_pend_q) begin
          rbuf_q <= m_rdata;
          h_dout <= ctrl_q.hwob ? m_rdata[HW-1:0] : m_rdata[WW-1:HW];
        end
      end

      if (go) begin
        unique case (s)
          SEL_CTRL: begin
            if (rnw_q)
              h_dout <= {{(HW-CTRL_W){1'b0}}, ctrl_q};
            else begin
              ctrl_q <= ctrl_t'(din_q[CTRL_W-1:0]);
              flag_q <= 1'b0;
            end
          end
          SEL_ADDR: begin
            if (rnw_q)
              h_dout <= hi ? sel_ptr[WW-1:HW] : sel_ptr[HW-1:0];
            flag_q <= ~flag_q;
          end
          default: begin
            flag_q <= ~flag_q;
            if (rnw_q) begin
              if (!flag_q) begin
                m_req     <= 1'b1;
                m_we      <= 1'b0;
                m_addr    <= p_q[0][AW-1:0];
                rd_pend_q <= 1'b1;
              end else
                h_dout <= hi ? rbuf_q[WW-1:HW] : rbuf_q[HW-1:0];
            end else begin
              if (!flag_q) begin
                if (hi) wbuf_q[WW-1:HW] <= din_q;
                else    wbuf_q[HW-1:0]  <= din_q;
              end else begin
                m_req      <= 1'b1;
                m_we       <= 1'b1;
                m_addr     <= p_q[1][AW-1:0];
                m_wdata    <= hi ? {din_q, wbuf_q[HW-1:0]} : {wbuf_q[WW-1:HW], din_q};
                rd_pend_q  <= 1'b0;
                inc_pend_q <= (s == SEL_DATA_INC);
              end
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/hp16_checker.sv
module hp16_checker #(
  parameter int AW = 20,
  parameter int WW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          hold,
  input logic          h_rdy,
  input logic          m_req,
  input logic          m_ack,
  input logic          m_we,
  input logic [AW-1:0] m_addr,
  input logic [WW-1:0] m_wdata
);
  // R1
  hold_blocks_rdy_chk: assert property (@(posedge clk) disable iff (rst)
    hold |=> !h_rdy);

  // R1
  hold_no_new_req_chk: assert property (@(posedge clk) disable iff (rst)
    (hold && !m_req) |=> !m_req);

  // R10
  req_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (m_req && !m_ack) |=> (m_req && $stable(m_we) && $stable(m_addr) && $stable(m_wdata)));

  // R10
  req_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (m_req && m_ack) |=> !m_req);

  // R10
  req_blocks_rdy_chk: assert property (@(posedge clk) disable iff (rst)
    m_req |-> !h_rdy);
endmodule

bind hostport16_slave hp16_checker #(.AW(AW), .WW(2*HW)) u_chk (.*);

// File: tb/hostport16_slave_test.sv
module hostport16_slave_test;
  localparam int HW = 16;
  localparam int AW = 20;
  localparam int WW = 32;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, hold, cs_n, ds1_n, ds2_n, rnw_i, m_req, m_we, m_ack, h_rdy;
  logic [1:0]    sel;
  logic [HW-1:0] din, h_dout;
  logic [AW-1:0] m_addr;
  logic [WW-1:0] m_wdata, m_rdata;

  hostport16_slave #(.HW(HW), .AW(AW)) uut (
    .clk(clk), .rst(rst), .hold(hold), .h_cs_n(cs_n), .h_ds1_n(ds1_n),
    .h_ds2_n(ds2_n), .h_sel(sel), .h_rnw(rnw_i), .h_din(din), .h_dout(h_dout),
    .h_rdy(h_rdy), .m_req(m_req), .m_we(m_we), .m_addr(m_addr),
    .m_wdata(m_wdata), .m_rdata(m_rdata), .m_ack(m_ack)
  );

  int checks = 0, fails = 0, cyc = 0;

  task automatic chk(input bit ok, input string msg, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %h expected %h", msg, act, exp);
    end
  endtask

  function automatic logic [31:0] fill(input logic [AW-1:0] a);
    return {12'hC3A, a} ^ 32'h0F0F_0000;
  endfunction

  // Internal memory responder, two cycles of latency
  logic [31:0] rmem [int];
  int lat;
  always @(posedge clk) begin
    if (rst) begin
      m_ack <= 1'b0; lat <= 0; m_rdata <= '0;
    end else begin
      m_ack <= 1'b0;
      if (m_req && !m_ack) begin
        if (lat == 1) begin
          m_ack <= 1'b1; lat <= 0;
          if (m_we) rmem[int'(m_addr)] = m_wdata;
          else m_rdata <= rmem.exists(int'(m_addr)) ? rmem[int'(m_addr)] : fill(m_addr);
        end else lat <= lat + 1;
      end
    end
  end

  // Reference model state
  logic [2:0]  mctrl;
  bit          mflag;
  logic [31:0] mra, mwa, mwbuf, mrbuf;
  logic [31:0] mmem [int];
  bit          q_we [$];
  logic [31:0] q_addr [$], q_data [$];

  // Per-clock comparison
  logic hold_pe;
  logic req_prev;
  always @(posedge clk) hold_pe <= hold;
  always @(negedge clk) begin
    if (rst) req_prev = 1'b0;
    else begin
      if (hold_pe) chk(!h_rdy, "R1 ready low while hold set", 32'(h_rdy), 0);
      if (m_req && !req_prev) begin
        if (q_we.size() == 0)
          chk(0, "R10 unexpected internal request", 32'(m_addr), 0);
        else begin
          bit we; logic [31:0] a, d;
          we = q_we.pop_front(); a = q_addr.pop_front(); d = q_data.pop_front();
          chk(m_we == we, "R6 R7 request direction", 32'(m_we), 32'(we));
          chk(m_addr == a[AW-1:0], "R8 R9 request address", 32'(m_addr), 32'(a[AW-1:0]));
          if (we) chk(m_wdata == d, "R4 R6 request write word", m_wdata, d);
        end
      end
      req_prev = m_req;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      fails++;
      $display("FAIL watchdog: run hung, got %0d cycles expected under 50000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  bit alt = 1'b0;
  task automatic bus(input logic [1:0] s, input bit rd, input logic [15:0] d, output logic [15:0] q);
    @(negedge clk);
    cs_n = 1'b0; sel = s; rnw_i = rd; din = d;
    if (alt) begin ds2_n = 1'b0; ds1_n = 1'b1; end
    else     begin ds1_n = 1'b0; ds2_n = 1'b1; end
    alt = !alt;
    repeat (4) @(negedge clk);
    while (!h_rdy) @(negedge clk);
    q = h_dout;
    cs_n = 1'b1; ds1_n = 1'b1; ds2_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic raw(input bit c, input bit a, input bit b, input logic [1:0] s, input logic [15:0] d);
    @(negedge clk);
    cs_n = c; ds1_n = a; ds2_n = b; sel = s; rnw_i = 1'b0; din = d;
    repeat (5) @(negedge clk);
    cs_n = 1'b1; ds1_n = 1'b1; ds2_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic mw(input logic [1:0] s, input logic [15:0] d);
    logic [15:0] q; bit hi; logic [31:0] w;
    hi = (mflag == mctrl[0]);
    case (s)
      2'b00: begin mctrl = d[2:0]; mflag = 0; end
      2'b10: begin
        if (!mctrl[1] || !mctrl[2]) mra = hi ? {d, mra[15:0]} : {mra[31:16], d};
        if (!mctrl[1] ||  mctrl[2]) mwa = hi ? {d, mwa[15:0]} : {mwa[31:16], d};
        mflag = !mflag;
      end
      default: begin
        if (!mflag) mwbuf = hi ? {d, mwbuf[15:0]} : {mwbuf[31:16], d};
        else begin
          w = hi ? {d, mwbuf[15:0]} : {mwbuf[31:16], d};
          q_we.push_back(1'b1); q_addr.push_back(mwa); q_data.push_back(w);
          mmem[int'(mwa[AW-1:0])] = w;
          if (s == 2'b01) begin mwa++; if (!mctrl[1]) mra++; end
        end
        mflag = !mflag;
      end
    endcase
    bus(s, 1'b0, d, q);
  endtask

  task automatic mr(input logic [1:0] s, input string tag);
    logic [15:0] e, q; bit hi; logic [31:0] sr;
    hi = (mflag == mctrl[0]);
    case (s)
      2'b00: e = {13'b0, mctrl};
      2'b10: begin
        sr = (mctrl[1] && mctrl[2]) ? mwa : mra;
        e = hi ? sr[31:16] : sr[15:0];
        mflag = !mflag;
      end
      default: begin
        if (!mflag) begin
          q_we.push_back(1'b0); q_addr.push_back(mra); q_data.push_back(0);
          mrbuf = mmem.exists(int'(mra[AW-1:0])) ? mmem[int'(mra[AW-1:0])] : fill(mra[AW-1:0]);
        end
        e = hi ? mrbuf[31:16] : mrbuf[15:0];
        if (mflag && s == 2'b01) begin mra++; if (!mctrl[1]) mwa++; end
        mflag = !mflag;
      end
    endcase
    bus(s, 1'b1, 16'h0, q);
    chk(q == e, tag, 32'(q), 32'(e));
  endtask

  initial begin
    rst = 1'b1; hold = 1'b1; cs_n = 1'b1; ds1_n = 1'b1; ds2_n = 1'b1;
    sel = 2'b00; rnw_i = 1'b0; din = '0;
    mctrl = 0; mflag = 0; mra = 0; mwa = 0; mwbuf = 0; mrbuf = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(h_rdy == 1'b0, "R1 reset state ready low under hold", 32'(h_rdy), 0);
    chk(h_dout == '0, "R1 reset state output zero", 32'(h_dout), 0);

    // R1: control write attempted while held is dropped
    raw(1'b0, 1'b0, 1'b1, 2'b00, 16'h0007);
    hold = 1'b0;
    repeat (2) @(negedge clk);
    chk(h_rdy == 1'b1, "R1 ready after hold release", 32'(h_rdy), 1);
    mr(2'b00, "R1 R3 control unchanged by held access");

    // R3 R4 R8: shared pointer, upper half first
    mw(2'b00, 16'h0000);
    mr(2'b00, "R3 control readback");
    mw(2'b10, 16'h0000); mw(2'b10, 16'h0010);
    mr(2'b10, "R4 R8 address upper half first");
    mr(2'b10, "R4 R8 address lower half second");

    // R2 R6 R9: writes with and without increment
    mw(2'b01, 16'hDEAD); mw(2'b01, 16'hBEEF);
    mw(2'b11, 16'h1234); mw(2'b11, 16'h5678);
    mw(2'b11, 16'h9ABC); mw(2'b11, 16'hDEF0);
    mr(2'b10, "R9 pointer unchanged by select 11");
    mr(2'b10, "R9 pointer unchanged by select 11 low");

    // R7: reads
    mw(2'b10, 16'h0000); mw(2'b10, 16'h0010);
    mr(2'b01, "R7 read first half"); mr(2'b01, "R7 read second half");
    mr(2'b11, "R2 R7 read no increment first"); mr(2'b11, "R2 R7 read no increment second");
    mr(2'b01, "R9 read after no increment"); mr(2'b01, "R9 read after no increment low");
    mr(2'b01, "R7 read unwritten word high"); mr(2'b01, "R7 read unwritten word low");

    // R4: low half first
    mw(2'b00, 16'h0001);
    mw(2'b10, 16'h0020); mw(2'b10, 16'h0000);
    mr(2'b10, "R4 address lower half first"); mr(2'b10, "R4 address upper half second");
    mw(2'b01, 16'h5555); mw(2'b01, 16'hAAAA);
    mw(2'b10, 16'h0020); mw(2'b10, 16'h0000);
    mr(2'b01, "R4 data lower half first"); mr(2'b01, "R4 data upper half second");

    // R5: badly qualified strobes start nothing
    raw(1'b0, 1'b0, 1'b0, 2'b00, 16'h0006);
    raw(1'b1, 1'b0, 1'b1, 2'b00, 16'h0006);
    mr(2'b00, "R5 control unchanged by unqualified strobes");

    // R8: dual pointers
    mw(2'b00, 16'h0002);
    mw(2'b10, 16'h0000); mw(2'b10, 16'h0010);
    mw(2'b00, 16'h0006);
    mw(2'b10, 16'h0000); mw(2'b10, 16'h0030);
    mr(2'b10, "R8 dual write pointer high"); mr(2'b10, "R8 dual write pointer low");
    mw(2'b01, 16'h1111); mw(2'b01, 16'h2222);
    mr(2'b01, "R8 dual read uses read pointer"); mr(2'b01, "R8 dual read second half");
    mr(2'b10, "R9 dual write pointer advanced high"); mr(2'b10, "R9 dual write pointer advanced low");
    mw(2'b00, 16'h0002);
    mr(2'b10, "R8 R9 dual read pointer high"); mr(2'b10, "R8 R9 dual read pointer low");

    // R3: control write restarts the halfword flag
    mw(2'b10, 16'hFFFF);
    mw(2'b00, 16'h0000);
    mw(2'b10, 16'h0000); mw(2'b10, 16'h0055);
    mr(2'b10, "R3 flag reset address high"); mr(2'b10, "R3 flag reset address low");

    repeat (10) @(negedge clk);
    chk(q_we.size() == 0, "R6 R7 all expected requests seen", 32'(q_we.size()), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule